// File: doc/BRIEF.md
# Byte-addressed load/store unit with alignment traps

This unit carries out the data-memory side of a small register machine. Each cycle it may take one 32-bit instruction word together with the two register values the surrounding pipeline has already read: the base value and the store value. Three kinds of work are possible. An immediate move writes the sign-extended 16-bit immediate straight to a register. A load reads one, two or four bytes from the private 4096-byte data memory and returns them zero-extended. A store writes the low one, two or four bytes of the store value into that memory.

The effective address is the base value plus the sign-extended immediate. Only its low twelve bits select a byte. Multi-byte data is little-endian. A halfword or word access at an address that is not naturally aligned is not split into smaller accesses. Instead it raises a trap flag and has no effect on memory or registers. All results leave through registers two clock edges after the instruction is presented: the write-back enable, the register index and the data, plus the trap flag.

The memory is organised as one byte-wide RAM per byte lane, so that each lane maps onto block RAM. A surrounding core supplies register operands and consumes the write-back port.

Top module: `ls_unit`

## Requirements
- R1: While reset is high, and on the edge after it, `wb_en_o` and `trap_o` are low. The results of an instruction presented with `valid_i` high at edge N appear on the outputs after edge N+2. An instruction still in flight when reset is applied produces no output.
- R2: Opcode field instr[31:26] = octal 020 (move) writes the immediate instr[15:0], sign-extended to 32 bits, to the register whose index is instr[20:16]. It does not touch memory.
- R3: The effective address is `base_val_i` plus the sign-extended immediate. Its low 12 bits select the byte, so negative displacements address below the base.
- R4: Opcode 021 (byte load) returns the addressed byte zero-extended to 32 bits, with the destination index taken from instr[20:16].
- R5: Opcode 022 (halfword load) returns the bytes at A and A+1 as {A+1, A}, zero-extended. Opcode 023 (word load) returns {A+3, A+2, A+1, A}.
- R6: Opcode 024 (byte store) writes bits 7:0 of `store_val_i` to address A only, and leaves the neighbouring bytes unchanged. It asserts no write-back.
- R7: Opcode 025 (halfword store) and opcode 026 (word store) write the low 16 or 32 bits of `store_val_i` little-endian from A upward. They assert no write-back.
- R8: A halfword access with address bit 0 set, or a word access with either of address bits 1:0 set, raises `trap_o` for one cycle. It does so with the same latency as a write-back.
- R9: A trapped access asserts no write-back and changes no memory byte.
- R10: With `valid_i` low, or with an opcode outside 020 to 026, the unit asserts neither write-back nor trap and leaves memory unchanged.
- R11: A load presented in the cycle right after a store to the same address returns the newly stored data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 32 | Instruction word: opcode 31:26, base register 25:21, data register 20:16, immediate 15:0 |
| base_val_i | input | 32 | Value of the base register |
| store_val_i | input | 32 | Value of the data register, used by stores |
| wb_en_o | output | 1 | Register write-back enable |
| wb_idx_o | output | 5 | Register index to write |
| wb_data_o | output | 32 | Data to write |
| trap_o | output | 1 | Unaligned-access trap |

## Verification
Two functions can meet at the same clock edge. The first pair is a misaligned store, whose trap detection must suppress the lane write enables that the store would otherwise raise at that very edge. The vector table provokes this with word and halfword stores at offsets 1 and 2, each followed by a word read of the surrounding location, which must show the old bytes. The second pair is a store's RAM write and the next instruction's RAM read of the same row at the following edge. A store followed back-to-back by a load of the same address exercises this, and the check is that the load returns the new value rather than the stale one.

// File: rtl/ls_pkg.sv
package ls_pkg;

  localparam int XLEN           = 32;
  localparam int BYTES_PER_WORD = XLEN / 8;
  localparam int LANE_W         = $clog2(BYTES_PER_WORD);
  localparam int IMM_W          = 16;
  localparam int REG_W          = 5;

  // instruction field positions
  localparam int OPC_HI = 31;
  localparam int OPC_LO = 26;
  localparam int RB_HI  = 20;
  localparam int RB_LO  = 16;
  localparam int RA_HI  = 25;
  localparam int RA_LO  = 21;

  typedef enum logic [5:0] {
    OP_MOVI = 6'o20,
    OP_LDB  = 6'o21,
    OP_LDH  = 6'o22,
    OP_LDW  = 6'o23,
    OP_STB  = 6'o24,
    OP_STH  = 6'o25,
    OP_STW  = 6'o26
  } ls_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

endpackage

// File: rtl/ls_decode.sv
module ls_decode
  import ls_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic                      valid_i,
  input  logic [XLEN-1:0]           instr_i,
  input  logic [XLEN-1:0]           base_val_i,
  input  logic [XLEN-1:0]           store_val_i,
  output logic                      wb_req_o,
  output logic                      load_o,
  output logic                      trap_o,
  output acc_size_e                 size_o,
  output logic [AW-1:0]             addr_o,
  output logic [BYTES_PER_WORD-1:0] lane_we_o,
  output logic [XLEN-1:0]           lane_wdata_o,
  output logic [XLEN-1:0]           imm_ext_o
);

  logic [5:0]                opc;
  logic [XLEN-1:0]           ea_full;
  logic                      is_mov, is_load, is_store;
  logic                      misalign;
  logic [LANE_W-1:0]         lane;
  logic [BYTES_PER_WORD-1:0] mask;
  logic                      unused_ea_hi;

  assign opc          = instr_i[OPC_HI:OPC_LO];
  assign imm_ext_o    = {{(XLEN-IMM_W){instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};
  assign ea_full      = base_val_i + imm_ext_o;
  assign addr_o       = ea_full[AW-1:0];
  assign lane         = ea_full[LANE_W-1:0];
  assign unused_ea_hi = ^ea_full[XLEN-1:AW];

  always_comb begin
    is_mov   = 1'b0;
    is_load  = 1'b0;
    is_store = 1'b0;
    size_o   = SZ_WORD;
    case (opc)
      OP_MOVI: is_mov = 1'b1;
      OP_LDB:  begin is_load  = 1'b1; size_o = SZ_BYTE; end
      OP_LDH:  begin is_load  = 1'b1; size_o = SZ_HALF; end
      OP_LDW:  begin is_load  = 1'b1; size_o = SZ_WORD; end
      OP_STB:  begin is_store = 1'b1; size_o = SZ_BYTE; end
      OP_STH:  begin is_store = 1'b1; size_o = SZ_HALF; end
      OP_STW:  begin is_store = 1'b1; size_o = SZ_WORD; end
      default: ;
    endcase
  end

  always_comb begin
    case (size_o)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = lane[0];
      default: misalign = (lane != '0);
    endcase
  end

  always_comb begin
    case (size_o)
      SZ_BYTE: begin
        mask         = BYTES_PER_WORD'(1) << lane;
        lane_wdata_o = {BYTES_PER_WORD{store_val_i[7:0]}};
      end
      SZ_HALF: begin
        mask         = BYTES_PER_WORD'(3) << lane;
        lane_wdata_o = {(BYTES_PER_WORD/2){store_val_i[15:0]}};
      end
      default: begin
        mask         = '1;
        lane_wdata_o = store_val_i;
      end
    endcase
  end

  assign load_o    = is_load;
  assign trap_o    = valid_i && (is_load || is_store) && misalign;
  assign wb_req_o  = valid_i && (is_mov || (is_load && !misalign));
  assign lane_we_o = (valid_i && is_store && !misalign) ? mask : '0;

endmodule

// File: rtl/ls_byte_ram.sv
module ls_byte_ram #(
  parameter int ROWS = 1024,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);

  logic [7:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wdata;
    rdata <= mem[row];
  end

endmodule

// File: rtl/ls_load_align.sv
module ls_load_align
  import ls_pkg::*;
(
  input  logic [XLEN-1:0]   row_data,
  input  logic [LANE_W-1:0] lane,
  input  acc_size_e         size,
  output logic [XLEN-1:0]   result
);

  logic [XLEN-1:0] shifted;

  assign shifted = row_data >> {lane, 3'b000};

  always_comb begin
    case (size)
      SZ_BYTE: result = XLEN'(shifted[7:0]);
      SZ_HALF: result = XLEN'(shifted[15:0]);
      default: result = shifted;
    endcase
  end

endmodule

// File: rtl/ls_unit.sv
module ls_unit
  import ls_pkg::*;
#(
  parameter int MEM_BYTES = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [XLEN-1:0]  instr_i,
  input  logic [XLEN-1:0]  base_val_i,
  input  logic [XLEN-1:0]  store_val_i,
  output logic             wb_en_o,
  output logic [REG_W-1:0] wb_idx_o,
  output logic [XLEN-1:0]  wb_data_o,
  output logic             trap_o
);

  localparam int AW    = $clog2(MEM_BYTES);
  localparam int ROWS  = MEM_BYTES / BYTES_PER_WORD;
  localparam int ROW_W = AW - LANE_W;

  logic                      dec_wb, dec_load, dec_trap;
  acc_size_e                 dec_size;
  logic [AW-1:0]             dec_addr;
  logic [BYTES_PER_WORD-1:0] lane_we;
  logic [XLEN-1:0]           lane_wdata;
  logic [XLEN-1:0]           dec_imm;
  logic [XLEN-1:0]           row_rdata;
  logic [XLEN-1:0]           load_val;
  logic                      unused_ra;

  // first stage: decoded request held while the RAM read completes
  logic              s1_wb, s1_load, s1_trap;
  acc_size_e         s1_size;
  logic [LANE_W-1:0] s1_lane;
  logic [REG_W-1:0]  s1_idx;
  logic [XLEN-1:0]   s1_mov;

  assign unused_ra = ^instr_i[RA_HI:RA_LO];

  ls_decode #(.AW(AW)) u_dec (
    .valid_i      (valid_i),
    .instr_i      (instr_i),
    .base_val_i   (base_val_i),
    .store_val_i  (store_val_i),
    .wb_req_o     (dec_wb),
    .load_o       (dec_load),
    .trap_o       (dec_trap),
    .size_o       (dec_size),
    .addr_o       (dec_addr),
    .lane_we_o    (lane_we),
    .lane_wdata_o (lane_wdata),
    .imm_ext_o    (dec_imm)
  );

  for (genvar g = 0; g < BYTES_PER_WORD; g++) begin : g_lane
    ls_byte_ram #(.ROWS(ROWS)) u_ram (
      .clk   (clk),
      .we    (lane_we[g]),
      .row   (dec_addr[AW-1:LANE_W]),
      .wdata (lane_wdata[8*g +: 8]),
      .rdata (row_rdata[8*g +: 8])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_wb   <= 1'b0;
      s1_load <= 1'b0;
      s1_trap <= 1'b0;
      s1_size <= SZ_WORD;
      s1_lane <= '0;
      s1_idx  <= '0;
      s1_mov  <= '0;
    end else begin
      s1_wb   <= dec_wb;
      s1_load <= dec_load;
      s1_trap <= dec_trap;
      s1_size <= dec_size;
      s1_lane <= dec_addr[LANE_W-1:0];
      s1_idx  <= instr_i[RB_HI:RB_LO];
      s1_mov  <= dec_imm;
    end
  end

  ls_load_align u_align (
    .row_data (row_rdata),
    .lane     (s1_lane),
    .size     (s1_size),
    .result   (load_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en_o   <= 1'b0;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
      trap_o    <= 1'b0;
    end else begin
      wb_en_o   <= s1_wb;
      wb_idx_o  <= s1_idx;
      wb_data_o <= s1_load ? load_val : s1_mov;
      trap_o    <= s1_trap;
    end
  end

  AST_TRAP_EXCL_WB: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> !wb_en_o); // R9

  AST_WB_LATENCY: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> $past(valid_i, 2)); // R1

  AST_TRAP_LATENCY: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> $past(valid_i, 2)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!s1_wb && !s1_trap)); // R10

  AST_WB_INDEX: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> (wb_idx_o == $past(instr_i[RB_HI:RB_LO], 2))); // R2

  AST_STORE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (lane_we != '0) |=> !s1_wb); // R7

  ls_ram_size_ok: assert final (ROWS * BYTES_PER_WORD == MEM_BYTES); // R3

endmodule

// File: tb/ls_unit_test.sv
`timescale 1ns/1ps
module ls_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] base_val = '0;
  logic [31:0] store_val = '0;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;
  logic        trap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ls_unit uut (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (valid),
    .instr_i     (instr),
    .base_val_i  (base_val),
    .store_val_i (store_val),
    .wb_en_o     (wb_en),
    .wb_idx_o    (wb_idx),
    .wb_data_o   (wb_data),
    .trap_o      (trap)
  );

  // fields: opcode(6) rb index(5) imm(16) base(32) store(32) exp_wb(1) exp_data(32) exp_trap(1)
  localparam int NV = 26;
  localparam logic [124:0] VEC [NV] = '{
    {6'o20, 5'd3,  16'h0066, 32'h0,   32'h0,        1'b1, 32'h00000066, 1'b0}, // R2 positive immediate
    {6'o20, 5'd4,  16'h8001, 32'h0,   32'h0,        1'b1, 32'hFFFF8001, 1'b0}, // R2 negative immediate
    {6'o26, 5'd7,  16'h0000, 32'h100, 32'h44332211, 1'b0, 32'h0,        1'b0}, // R7 word store
    {6'o23, 5'd5,  16'h0000, 32'h100, 32'h0,        1'b1, 32'h44332211, 1'b0}, // R5 word load
    {6'o21, 5'd6,  16'h0003, 32'h100, 32'h0,        1'b1, 32'h00000044, 1'b0}, // R4 byte load lane 3
    {6'o22, 5'd8,  16'hFFFE, 32'h104, 32'h0,        1'b1, 32'h00004433, 1'b0}, // R3 R5 negative offset
    {6'o24, 5'd7,  16'h0000, 32'h101, 32'hFFFFFFAB, 1'b0, 32'h0,        1'b0}, // R6 byte store
    {6'o23, 5'd9,  16'h0000, 32'h100, 32'h0,        1'b1, 32'h4433AB11, 1'b0}, // R6 neighbours kept
    {6'o25, 5'd7,  16'h0002, 32'h100, 32'h1234CDEF, 1'b0, 32'h0,        1'b0}, // R7 halfword store
    {6'o23, 5'd10, 16'h0000, 32'h100, 32'h0,        1'b1, 32'hCDEFAB11, 1'b0}, // R7 readback
    {6'o21, 5'd11, 16'h0002, 32'h100, 32'h0,        1'b1, 32'h000000EF, 1'b0}, // R4 zero extension
    {6'o22, 5'd12, 16'h0003, 32'h100, 32'h0,        1'b0, 32'h0,        1'b1}, // R8 odd halfword
    {6'o23, 5'd13, 16'h0002, 32'h100, 32'h0,        1'b0, 32'h0,        1'b1}, // R8 word offset 2
    {6'o23, 5'd13, 16'h0001, 32'h100, 32'h0,        1'b0, 32'h0,        1'b1}, // R8 word offset 1
    {6'o26, 5'd7,  16'h0002, 32'h100, 32'hDEADBEEF, 1'b0, 32'h0,        1'b1}, // R9 trapped word store
    {6'o23, 5'd14, 16'h0000, 32'h100, 32'h0,        1'b1, 32'hCDEFAB11, 1'b0}, // R9 memory unchanged
    {6'o25, 5'd7,  16'h0001, 32'h100, 32'h0,        1'b0, 32'h0,        1'b1}, // R9 trapped halfword store
    {6'o23, 5'd15, 16'h0000, 32'h100, 32'h0,        1'b1, 32'hCDEFAB11, 1'b0}, // R9 memory unchanged
    {6'o27, 5'd16, 16'h0000, 32'h100, 32'h0,        1'b0, 32'h0,        1'b0}, // R10 unused opcode
    {6'o00, 5'd17, 16'h0000, 32'h100, 32'h0,        1'b0, 32'h0,        1'b0}, // R10 foreign opcode
    {6'o23, 5'd18, 16'h0000, 32'h100, 32'h0,        1'b1, 32'hCDEFAB11, 1'b0}, // R10 memory unchanged
    {6'o23, 5'd19, 16'hFF00, 32'h200, 32'h0,        1'b1, 32'hCDEFAB11, 1'b0}, // R3 displacement -256
    {6'o24, 5'd7,  16'h0FFF, 32'h0,   32'h0000005A, 1'b0, 32'h0,        1'b0}, // R6 last byte
    {6'o21, 5'd20, 16'h0FFF, 32'h0,   32'h0,        1'b1, 32'h0000005A, 1'b0}, // R4 last byte
    {6'o22, 5'd21, 16'h0000, 32'h102, 32'h0,        1'b1, 32'h0000CDEF, 1'b0}, // R5 upper halfword
    {6'o22, 5'd22, 16'h0000, 32'h100, 32'h0,        1'b1, 32'h0000AB11, 1'b0}  // R5 lower halfword
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic v, input logic [5:0] op, input logic [4:0] rb,
                       input logic [15:0] imm, input logic [31:0] b, input logic [31:0] s);
    valid     = v;
    instr     = {op, 5'd1, rb, imm};
    base_val  = b;
    store_val = s;
  endtask

  task automatic check_out(input string req, input logic ew, input logic [4:0] ei,
                           input logic [31:0] ed, input logic et);
    check(wb_en === ew, {req, " wb_en"}, 32'(wb_en), 32'(ew));
    check(trap === et, {req, " trap"}, 32'(trap), 32'(et));
    if (ew) begin
      check(wb_idx === ei, {req, " wb_idx"}, 32'(wb_idx), 32'(ei));
      check(wb_data === ed, {req, " wb_data"}, wb_data, ed);
    end
  endtask

  initial begin
    @(negedge clk);
    check_out("R1 in reset", 1'b0, 5'd0, 32'h0, 1'b0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_out("R1 after reset", 1'b0, 5'd0, 32'h0, 1'b0);

    // table walk: one instruction, then two edges to its result
    for (int i = 0; i < NV; i++) begin
      logic [124:0] e;
      e = VEC[i];
      drive(1'b1, e[124:119], e[118:114], e[113:98], e[97:66], e[65:34]);
      @(posedge clk);
      @(negedge clk);
      drive(1'b0, 6'o00, 5'd0, 16'h0, 32'h0, 32'h0);
      @(posedge clk);
      @(negedge clk);
      check_out($sformatf("vector %0d", i), e[33], e[118:114], e[32:1], e[0]);
    end

    // R10: valid low with a move presented
    drive(1'b0, 6'o20, 5'd9, 16'h1234, 32'h0, 32'h0);
    repeat (2) @(negedge clk);
    check_out("R10 valid low", 1'b0, 5'd0, 32'h0, 1'b0);

    // R11: store then load of the same word on consecutive cycles
    drive(1'b1, 6'o26, 5'd7, 16'h0000, 32'h200, 32'hA5A55A5A);
    @(negedge clk);
    drive(1'b1, 6'o23, 5'd23, 16'h0000, 32'h200, 32'h0);
    @(negedge clk);
    drive(1'b0, 6'o00, 5'd0, 16'h0, 32'h0, 32'h0);
    check_out("R11 store slot", 1'b0, 5'd0, 32'h0, 1'b0);
    @(negedge clk);
    check_out("R11 load after store", 1'b1, 5'd23, 32'hA5A55A5A, 1'b0);

    // R1: reset drops an instruction in flight
    drive(1'b1, 6'o20, 5'd2, 16'h0007, 32'h0, 32'h0);
    @(negedge clk);
    drive(1'b0, 6'o00, 5'd0, 16'h0, 32'h0, 32'h0);
    rst = 1'b1;
    @(negedge clk);
    check_out("R1 flush", 1'b0, 5'd0, 32'h0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check_out("R1 flush after", 1'b0, 5'd0, 32'h0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule